// File: doc/BRIEF.md
# Potentiometer Preset Register Bank with Store Timer

This block keeps the preset values for a group of digitally controlled potentiometers: several small persistent registers per wiper, sixteen of six bits in the default build, held as flops. A command decoder upstream strobes one of three store requests when a command has been fully received. The first writes a host byte into one register. The second copies one wiper's current value into one of its registers. The third copies every wiper into the register of the same index in its own set. A store request only arms a pending store. Nothing changes in the bank until the chip-select rising edge arrives.

At that edge the pending store runs only when write protection is released and no earlier store is still running. It then occupies a fixed number of clocks, during which the busy flag reads 1. The registers take their new contents at the moment the flag drops. Reads and the wiper-load outputs stay available at all times. Selecting register zero on the load port gives the values used for power-on recall of the wipers.

Top module: `pot_store_bank`

## Requirements
- R1: After reset, `wip` is 0 and every register of every pot holds the parameter `INIT_VAL`.
- R2: A host write request (`wr_req`) loads nothing by itself. Its value `wr_data` reaches register (`req_pot`, `req_reg`) only once a later `cs_rise` has started a store.
- R3: `wip` rises on the clock after the edge that samples an accepted `cs_rise`, and stays 1 for exactly `STORE_CYC` clocks.
- R4: While `wip` is 1, every register and every read keeps its old value. The stored value becomes visible in the same clock in which `wip` returns to 0.
- R5: If `wp_n` is 0 when `cs_rise` is sampled, no store takes place: `wip` stays 0 and all registers keep their values.
- R6: A single transfer request (`xfer_req`) stores the value that slice `req_pot` of `wiper_vals` held in the request cycle, not its value at `cs_rise`. Slice p occupies bits p*W+W-1..p*W.
- R7: A global transfer request (`gxfer_req`) stores each pot's `wiper_vals` slice into that pot's register `req_reg`, for all pots in one store.
- R8: Every `cs_rise` discards the pending store, whether or not the store was accepted. A `cs_rise` with nothing pending starts no store.
- R9: While `wip` is 1, store requests and `cs_rise` are ignored. When the running store ends, no second store follows and the registers hold the first store's value.
- R10: `rd_data` combinationally shows register (`rd_pot`, `rd_reg`). Slice p of `ld_vals` shows register `ld_reg` of pot p, so `ld_reg` = 0 gives the power-on recall presets. Both ports work during a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Complete host write command received |
| xfer_req | input | 1 | Complete single wiper-to-register transfer received |
| gxfer_req | input | 1 | Complete global wiper-to-register transfer received |
| req_pot | input | 2 | Pot index of the request |
| req_reg | input | 2 | Register index of the request |
| wr_data | input | 6 | Host data for a write request |
| wiper_vals | input | 24 | Current wiper values, pot p in bits p*6+5..p*6 |
| cs_rise | input | 1 | One-clock strobe for the chip-select rising edge |
| wp_n | input | 1 | Write enable, 0 blocks stores |
| rd_pot | input | 2 | Read pot index |
| rd_reg | input | 2 | Read register index |
| rd_data | output | 6 | Selected register contents |
| ld_reg | input | 2 | Register index for wiper loads |
| ld_vals | output | 24 | Register ld_reg of each pot, pot p in bits p*6+5..p*6 |
| wip | output | 1 | Store in progress |

## Verification
A wrong store counter shows directly on `wip`, as a busy window one or more clocks too short or too long, or as a window that never closes. The bench counts that window for each store. A pending flag that fails to clear shows up one store later: a register changes, or `wip` rises, after a `cs_rise` that should have been inert. The bench reads the whole bank after each scenario, so a wrong mask or a wrong captured value is caught at the first full read-back after the faulty store ends. Early commitment shows on `rd_data` during the busy window itself.

// File: rtl/pot_store_bank.sv
module pot_store_bank #(
  parameter int NPOT = 4,
  parameter int NREG = 4,
  parameter int W = 6,
  parameter int STORE_CYC = 20,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_req,
  input  logic                       xfer_req,
  input  logic                       gxfer_req,
  input  logic [$clog2(NPOT)-1:0]    req_pot,
  input  logic [$clog2(NREG)-1:0]    req_reg,
  input  logic [W-1:0]               wr_data,
  input  logic [NPOT*W-1:0]          wiper_vals,
  input  logic                       cs_rise,
  input  logic                       wp_n,
  input  logic [$clog2(NPOT)-1:0]    rd_pot,
  input  logic [$clog2(NREG)-1:0]    rd_reg,
  output logic [W-1:0]               rd_data,
  input  logic [$clog2(NREG)-1:0]    ld_reg,
  output logic [NPOT*W-1:0]          ld_vals,
  output logic                       wip
);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(STORE_CYC + 1);
  localparam int BW = NPOT * NREG * W;

  logic [BW-1:0]     bank;
  logic              pend;
  logic              busy;
  logic [CW-1:0]     cnt;
  logic [NPOT-1:0]   pmask;
  logic [NPOT*W-1:0] pvals;
  logic [RW-1:0]     preg;

  wire any_req = wr_req | xfer_req | gxfer_req;
  wire start   = cs_rise & pend & wp_n & ~busy;
  wire done    = busy && (cnt == '0);

  assign wip     = busy;
  assign rd_data = bank[(int'(rd_pot) * NREG + int'(rd_reg)) * W +: W];

  for (genvar p = 0; p < NPOT; p++) begin : g_ld
    assign ld_vals[p*W +: W] = bank[(p * NREG + int'(ld_reg)) * W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank  <= {(NPOT*NREG){INIT_VAL}};
      pend  <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      pmask <= '0;
      pvals <= '0;
      preg  <= '0;
    end else begin
      if (cs_rise) pend <= 1'b0;
      if (any_req && !busy) begin
        pend  <= 1'b1;
        preg  <= req_reg;
        pvals <= wiper_vals;
        if (wr_req) begin
          pmask <= NPOT'(1) << req_pot;
          pvals[int'(req_pot)*W +: W] <= wr_data;
        end else if (xfer_req) begin
          pmask <= NPOT'(1) << req_pot;
        end else begin
          pmask <= '1;
        end
      end
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(STORE_CYC - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if (done) begin
        for (int p = 0; p < NPOT; p++) begin
          for (int r = 0; r < NREG; r++) begin
            if (pmask[p] && preg == RW'(r))
              bank[(p*NREG + r)*W +: W] <= pvals[p*W +: W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/pot_store_bank_chk.sv
module pot_store_bank_chk #(
  parameter int STORE_CYC = 20,
  parameter int BW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          wp_n,
  input logic          wip,
  input logic [BW-1:0] bank
);
  localparam int RC = $clog2(STORE_CYC + 2);
  logic [RC-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)   run <= '0;
    else if (wip) run <= run + 1'b1;
    else          run <= '0;
  end

  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> run == RC'(STORE_CYC));

  a_r3_window_cap: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> run < RC'(STORE_CYC));

  a_r2_start_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise));

  a_r4_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> $fell(wip));

  a_r5_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !wp_n && !wip) |=> !wip);
endmodule

bind pot_store_bank pot_store_bank_chk #(.STORE_CYC(STORE_CYC), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .wp_n(wp_n), .wip(wip), .bank(bank)
);

// File: tb/pot_store_bank_bench.sv
module pot_store_bank_bench;
  localparam int SC = 20;
  localparam logic [5:0] INIT = 6'h15;

  logic clk = 0, rst_n = 0;
  logic wr_req = 0, xfer_req = 0, gxfer_req = 0, cs_rise = 0, wp_n = 1;
  logic [1:0] req_pot = 0, req_reg = 0, rd_pot = 0, rd_reg = 0, ld_reg = 0;
  logic [5:0] wr_data = 0, rd_data;
  logic [23:0] wiper_vals = 0, ld_vals;
  logic wip;
  int checks = 0, errors = 0;
  logic [5:0] exp_m [4][4];

  pot_store_bank #(.STORE_CYC(SC), .INIT_VAL(INIT)) u_pot_store_bank (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .xfer_req(xfer_req), .gxfer_req(gxfer_req),
    .req_pot(req_pot), .req_reg(req_reg), .wr_data(wr_data), .wiper_vals(wiper_vals),
    .cs_rise(cs_rise), .wp_n(wp_n), .rd_pot(rd_pot), .rd_reg(rd_reg), .rd_data(rd_data),
    .ld_reg(ld_reg), .ld_vals(ld_vals), .wip(wip));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int p, input int r, output logic [5:0] v);
    rd_pot = 2'(p); rd_reg = 2'(r); #1; v = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [5:0] v;
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) begin
        rd(p, r, v);
        chk(tag, v, exp_m[p][r]);
      end
  endtask

  // kind: 0 host write, 1 single transfer, 2 global transfer
  task automatic req(input int kind, input int p, input int r, input logic [5:0] d);
    @(negedge clk);
    wr_req = (kind == 0); xfer_req = (kind == 1); gxfer_req = (kind == 2);
    req_pot = 2'(p); req_reg = 2'(r); wr_data = d;
    @(negedge clk);
    wr_req = 0; xfer_req = 0; gxfer_req = 0;
  endtask

  task automatic pulse_cs;
    @(negedge clk); cs_rise = 1;
    @(negedge clk); cs_rise = 0;
  endtask

  task automatic wait_store(input string tag);
    int n = 0;
    while (wip && n < 100) begin n++; @(negedge clk); end
    chk(tag, n, SC);
  endtask

  task automatic t_reset;
    chk("R1 wip after reset", wip, 0);
    check_all("R1 init value");
  endtask

  task automatic t_host_write;
    logic [5:0] v;
    req(0, 2, 1, 6'h2A);
    rd(2, 1, v); chk("R2 deferred before cs", v, exp_m[2][1]);
    pulse_cs;
    chk("R3 wip raised", wip, 1);
    rd(2, 1, v); chk("R4 old value while busy", v, exp_m[2][1]);
    wait_store("R3 window length");
    exp_m[2][1] = 6'h2A;
    rd(2, 1, v); chk("R2 value stored", v, 6'h2A);
    check_all("R4 other registers");
  endtask

  task automatic t_xfer_single;
    wiper_vals = {6'h3C, 6'h2B, 6'h11, 6'h05};
    req(1, 1, 3, 6'h00);
    wiper_vals = {6'h01, 6'h02, 6'h03, 6'h04};
    pulse_cs;
    wait_store("R3 window single xfer");
    exp_m[1][3] = 6'h11;
    check_all("R6 single transfer snapshot");
  endtask

  task automatic t_xfer_global;
    wiper_vals = {6'h3F, 6'h23, 6'h12, 6'h01};
    req(2, 0, 2, 6'h00);
    pulse_cs;
    wait_store("R3 window global xfer");
    exp_m[0][2] = 6'h01; exp_m[1][2] = 6'h12; exp_m[2][2] = 6'h23; exp_m[3][2] = 6'h3F;
    check_all("R7 global transfer");
  endtask

  task automatic t_protect;
    wp_n = 0;
    req(0, 0, 0, 6'h33);
    pulse_cs;
    chk("R5 no wip when protected", wip, 0);
    wp_n = 1;
    pulse_cs;
    chk("R8 pending dropped after cs", wip, 0);
    pulse_cs;
    chk("R8 cs with nothing pending", wip, 0);
    check_all("R5 registers untouched");
  endtask

  task automatic t_busy;
    logic [5:0] v;
    int n = 0;
    req(0, 3, 0, 6'h07);
    pulse_cs;
    req(0, 3, 0, 6'h3E);
    rd(2, 1, v); chk("R10 read during store", v, 6'h2A);
    pulse_cs;
    while (wip && n < 100) begin n++; @(negedge clk); end
    chk("R3 busy window total", n + 4, SC);
    exp_m[3][0] = 6'h07;
    rd(3, 0, v); chk("R9 first store kept", v, 6'h07);
    repeat (3) @(negedge clk);
    chk("R9 no second store", wip, 0);
    pulse_cs;
    chk("R9 request while busy dropped", wip, 0);
    check_all("R9 bank after busy test");
  endtask

  task automatic t_load;
    ld_reg = 0; #1;
    chk("R10 recall presets", ld_vals, {exp_m[3][0], exp_m[2][0], exp_m[1][0], exp_m[0][0]});
    ld_reg = 2; #1;
    chk("R10 load set 2", ld_vals, {exp_m[3][2], exp_m[2][2], exp_m[1][2], exp_m[0][2]});
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) exp_m[p][r] = INIT;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_host_write;
    t_xfer_single;
    t_xfer_global;
    t_protect;
    t_busy;
    t_load;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule